// File: doc/BRIEF.md
# Dual Indirect Command/Data Register Port

This block is a slave on an asynchronous microprocessor bus. It gives the processor four 16-bit ports. An active-low select and two address bits choose the port. Separate active-low strobes set the direction of each access. The chip has two controller halves, a host side and a device side, and each half has its own command port and its own data port. Software writes an 8-bit register code to a command port. After that, every access to the matching data port reaches the register that the code names.

Each half holds a small register file. Its entries include a DMA configuration word at code 21h and a transfer count at code 22h. A code with bit 7 clear requests a read, and the same code with bit 7 set requests a write. A code stays latched until software replaces it, so one command can serve any number of data accesses.

The write strobe passes through a two-flop synchronizer. A write is acted on exactly once, when the synchronized strobe rises. Read data is driven combinationally while the select and read strobe are both low.

Top module: `dual_indirect_port`

## Requirements
- R1: After reset no code is latched in either half and all registers hold 0000h, so any data-port read returns 0000h.
- R2: With cs_n low, addr selects the port: 00 host data, 01 host command, 10 device data, 11 device command.
- R3: A write to a command port latches din[7:0] as that half's code. It takes effect at the third rising clock edge after wr_n rises.
- R4: A data-port write stores din into register i when the latched code has bit 7 set and bits 6:0 equal REG_BASE+i, with i below NUM_REGS.
- R5: A data-port read returns register i on dout when the latched code has bit 7 clear and equals REG_BASE+i.
- R6: A latched code stays in force for any number of later data-port accesses.
- R7: A data access with no code latched, or with a code outside REG_BASE..REG_BASE+NUM_REGS-1, reads 0000h, and its write changes no register.
- R8: A data write under a read code (bit 7 clear) is ignored. A data read under a write code (bit 7 set) returns 0000h.
- R9: A read of a command port returns 0000h and does not change the latched code.
- R10: The host and device halves keep separate codes and registers. An access to one half never changes the other.
- R11: dout is 0000h whenever cs_n or rd_n is high.
- R12: A write strobe given while cs_n is high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select |
| addr | input | 2 | Port choice |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | DATA_W | Write data from the processor |
| dout | output | DATA_W | Read data to the processor |

## Verification
The bench uses the default parameters: 16-bit data, four registers per half, and base code 20h. With these values, codes 20h through 23h reach real registers, including 21h and 22h. Codes such as 30h and B0h fall outside the window, which lets the bench check that out-of-range codes are ignored. The same code sent to both halves shows that the halves do not share state. Mismatched direction bits, command-port reads, and strobes without a select are each followed by a read of the register that could have been disturbed.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    PORT_HDATA = 2'b00,
    PORT_HCMD  = 2'b01,
    PORT_DDATA = 2'b10,
    PORT_DCMD  = 2'b11
  } port_sel_e;

  // bit 7 of a code marks a write request
  function automatic logic code_is_write(input logic [CODE_W-1:0] c);
    return c[CODE_W-1];
  endfunction

  // distance of a code from the base of the register window
  function automatic logic [CODE_W-2:0] code_offset(input logic [CODE_W-1:0] c,
                                                    input logic [CODE_W-2:0] base);
    return c[CODE_W-2:0] - base;
  endfunction

  function automatic logic code_in_window(input logic [CODE_W-1:0] c,
                                          input logic [CODE_W-2:0] base,
                                          input int n);
    logic [CODE_W-2:0] off;
    off = code_offset(c, base);
    return (c[CODE_W-2:0] >= base) && (int'(off) < n);
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [1:0]        commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  logic wr_s1, wr_s2, wr_s3;
  logic cs_s1, cs_s2, held_cs;
  logic [1:0] addr_s1, addr_s2, held_addr;
  logic [DATA_W-1:0] din_s1, din_s2, held_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s1 <= 1'b1; wr_s2 <= 1'b1; wr_s3 <= 1'b1;
      cs_s1 <= 1'b1; cs_s2 <= 1'b1; held_cs <= 1'b1;
      addr_s1 <= '0; addr_s2 <= '0; held_addr <= '0;
      din_s1 <= '0; din_s2 <= '0; held_din <= '0;
    end else begin
      wr_s1 <= wr_n;  wr_s2 <= wr_s1;  wr_s3 <= wr_s2;
      cs_s1 <= cs_n;  cs_s2 <= cs_s1;
      addr_s1 <= addr; addr_s2 <= addr_s1;
      din_s1 <= din;  din_s2 <= din_s1;
      if (!wr_s2) begin
        held_cs   <= cs_s2;
        held_addr <= addr_s2;
        held_din  <= din_s2;
      end
    end
  end

  // deasserting edge of the synchronized strobe, qualified by the captured select
  assign commit      = wr_s2 && !wr_s3 && !held_cs;
  assign commit_addr = held_addr;
  assign commit_data = held_din;

  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/cmd_half.sv
module cmd_half
  import dip_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          NUM_REGS = 4,
  parameter logic [6:0]  REG_BASE = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              reg_we
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [CODE_W-1:0] cmd_q;
  logic              cmd_valid_q;
  logic              hit;
  logic [CODE_W-2:0] off;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      cmd_valid_q <= 1'b0;
    end else if (cmd_we) begin
      cmd_q       <= wdata[CODE_W-1:0];
      cmd_valid_q <= 1'b1;
    end
  end

  assign off    = code_offset(cmd_q, REG_BASE);
  assign idx    = off[IDX_W-1:0];
  assign hit    = cmd_valid_q && code_in_window(cmd_q, REG_BASE, NUM_REGS);
  assign reg_we = data_we && hit && code_is_write(cmd_q);
  assign rdata  = (hit && !code_is_write(cmd_q)) ? regs[idx] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (reg_we && idx == IDX_W'(g))        regs[g] <= wdata;
    end
  end

  // checker state
  logic [IDX_W-1:0]  chk_idx;
  logic [DATA_W-1:0] chk_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin chk_idx <= '0; chk_data <= '0; end
    else begin chk_idx <= idx; chk_data <= wdata; end
  end

  a_r4_store: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> regs[chk_idx] == chk_data);
  a_r3_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_valid_q && cmd_q == chk_data[CODE_W-1:0]);
  a_r7_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_q |-> rdata == '0);
endmodule

// File: rtl/dual_indirect_port.sv
module dual_indirect_port
  import dip_pkg::*;
#(
  parameter int         DATA_W   = 16,
  parameter int         NUM_REGS = 4,
  parameter logic [6:0] REG_BASE = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [1:0]        addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int HALVES = 2;

  logic              commit;
  logic [1:0]        commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [HALVES-1:0] cmd_we, data_we, reg_we;
  logic [DATA_W-1:0] half_rdata [HALVES];

  strobe_sync #(.DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .addr(addr), .din(din),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [1:0] DATA_SEL = 2'(2 * h);
    localparam logic [1:0] CMD_SEL  = 2'(2 * h + 1);
    assign cmd_we[h]  = commit && commit_addr == CMD_SEL;
    assign data_we[h] = commit && commit_addr == DATA_SEL;
    cmd_half #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .REG_BASE(REG_BASE)) u_half (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we[h]), .data_we(data_we[h]),
      .wdata(commit_data), .rdata(half_rdata[h]), .reg_we(reg_we[h])
    );
  end

  // odd addresses are command ports: they read as zero
  assign dout = (!cs_n && !rd_n && !addr[0]) ? half_rdata[addr[1]] : '0;

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, reg_we}));
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> dout == '0);
endmodule

// File: tb/dual_indirect_port_test.sv
module dual_indirect_port_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [15:0] din = '0, dout;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dual_indirect_port uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout));

  localparam logic [1:0] HD = 2'b00, HC = 2'b01, DD = 2'b10, DC = 2'b11;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs_n = !sel; addr = a; din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk);
    d = dout;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    bus_read(HD, v); check("R1 host data after reset", v, 16'h0000);
    bus_read(DD, v); check("R1 device data after reset", v, 16'h0000);
  endtask

  task automatic t_write_read;
    logic [15:0] v;
    bus_write(HC, 16'h00A1); bus_write(HD, 16'h1234);
    bus_write(HC, 16'h0021);
    bus_read(HD, v); check("R5 R3 read dma config", v, 16'h1234);
    bus_read(HD, v); check("R6 repeated read same code", v, 16'h1234);
  endtask

  task automatic t_halves;
    logic [15:0] v;
    bus_write(HC, 16'h00A2); bus_write(HD, 16'hBEEF);
    bus_write(DC, 16'h00A2); bus_write(DD, 16'h5A5A);
    bus_write(HC, 16'h0022); bus_write(DC, 16'h0022);
    bus_read(HD, v); check("R10 host counter", v, 16'hBEEF);
    bus_read(DD, v); check("R2 R4 device counter", v, 16'h5A5A);
    bus_write(DC, 16'h0021);
    bus_read(DD, v); check("R10 device config untouched", v, 16'h0000);
  endtask

  task automatic t_unknown;
    logic [15:0] v;
    bus_write(HC, 16'h0030);
    bus_read(HD, v); check("R7 unknown read code", v, 16'h0000);
    bus_write(HC, 16'h00B0); bus_write(HD, 16'h1111);
    bus_write(HC, 16'h0020);
    bus_read(HD, v); check("R7 reg0 not hit by out-of-window write", v, 16'h0000);
  endtask

  task automatic t_mismatch;
    logic [15:0] v;
    bus_write(HC, 16'h0021); bus_write(HD, 16'hFFFF);
    bus_read(HD, v); check("R8 write under read code ignored", v, 16'h1234);
    bus_write(HC, 16'h00A1);
    bus_read(HD, v); check("R8 read under write code", v, 16'h0000);
  endtask

  task automatic t_cmd_read;
    logic [15:0] v;
    bus_write(HC, 16'h0021);
    bus_read(HC, v); check("R9 host command read", v, 16'h0000);
    bus_read(DC, v); check("R9 device command read", v, 16'h0000);
    bus_read(HD, v); check("R9 code kept after command read", v, 16'h1234);
  endtask

  task automatic t_no_select;
    logic [15:0] v;
    bus_write(HC, 16'h00A3);
    bus_write(HD, 16'h7777, 1'b0);
    bus_write(HC, 16'h0023);
    bus_read(HD, v); check("R12 unselected write ignored", v, 16'h0000);
    bus_write(HC, 16'h00A3);
    bus_write(HD, 16'h7777);
    bus_write(HC, 16'h0023);
    bus_read(HD, v); check("R4 selected write lands", v, 16'h7777);
  endtask

  task automatic t_idle;
    bus_write(HC, 16'h0021);
    @(negedge clk); cs_n = 1'b0; addr = HD; rd_n = 1'b1;
    @(negedge clk); check("R11 rd_n high", dout, 16'h0000);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); check("R11 cs_n high", dout, 16'h0000);
    rd_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_halves();
    t_unknown();
    t_mismatch();
    t_cmd_read();
    t_no_select();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule